// File: doc/BRIEF.md
# Reset and Exception Entry Controller

This block sits next to a 32-bit processor core and decides, each clock cycle, whether the core has to abandon its current flow and jump somewhere else. It watches three reset sources (an active-low power-on pin, an active-low manual reset pin and a reset command from the debug port) and a translation-miss request from the memory management unit. When one of them wins, it loads an event code and the new status word, and it drives a one-cycle redirect strobe together with the target address. For a miss it also records where the fault happened.

On a translation miss the controller keeps the faulting PC and status word. It captures the logical address and the virtual page number together with the current address-space identifier. It also advances the way-replacement counter that the TLB refill path uses. Instruction decode, the TLB lookup and interrupt prioritisation live elsewhere.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Priority and codes. Power-on reset (`por_n` low) beats a debug reset command, which beats manual reset (`mrst_n` low). The event code becomes 0x000 for power-on and debug resets and 0x020 for manual reset.
- R2: Any reset sets the vector base to 0x00000000. It loads the status word with 0x700000F0, that is bits 30 (privileged mode), 29 (register bank) and 28 (block) set, the interrupt mask in bits 7:4 set to 1111, and all other bits clear. The branch target becomes 0xA0000000.
- R3: A translation miss with no reset present sets the event code to 0x040 for a read (`miss_is_write` = 0) and to 0x060 for a write.
- R4: A miss copies `cur_pc` to the saved PC and `cur_sr` to the saved status. The new status word is `cur_sr` with bits 30, 29 and 28 forced to 1. The target is the vector base plus 0x400.
- R5: A miss writes the full `miss_addr` to the fault address output. The page-entry output gets `miss_addr[31:10]` in bits 31:10, zeros in bits 9:8 and `cur_asid` in bits 7:0.
- R6: On a miss with no way disabled, the 2-bit replacement counter increments by one and wraps from 3 to 0.
- R7: On a miss with at least one way disabled, the counter loads the index of the lowest-numbered disabled way.
- R8: After a power-on reset the two status pins read 11. After any other entry they read 00.
- R9: Every result appears on the clock edge that samples the request, and the redirect strobe is high for exactly the cycles that follow an accepted request. With no request, the redirect strobe is 0 and every output holds.
- R10: A miss in the same cycle as any reset is ignored. No reset alters the saved PC, saved status, fault address or page-entry outputs.
- R11: Power-on reset clears the replacement counter to 0. The other resets leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, sampled synchronously |
| mrst_n | input | 1 | Manual reset, active low |
| dbg_rst | input | 1 | Debug-port reset command, active high |
| miss_req | input | 1 | Translation miss request |
| miss_is_write | input | 1 | Miss access direction, 1 = write |
| miss_addr | input | 32 | Faulting logical address |
| cur_pc | input | 32 | PC of the faulting instruction |
| cur_sr | input | 32 | Status word at the time of the fault |
| cur_asid | input | 8 | Current address-space identifier |
| way_dis | input | 4 | Per-way disable flags, bit i = way i |
| redirect | output | 1 | Redirect strobe |
| target_pc | output | 32 | Branch target |
| evt_code | output | 12 | Exception event code |
| vbr | output | 32 | Vector base |
| sr | output | 32 | Status word to load |
| spc | output | 32 | Saved PC |
| ssr | output | 32 | Saved status |
| fault_addr | output | 32 | Captured fault address |
| pteh | output | 32 | Page number and ASID of the miss |
| repl_way | output | 2 | Way-replacement counter |
| status_pins | output | 2 | External status pins |

## Verification
Every output is a flop loaded on the edge that samples the request, so each result is due exactly one rising edge after the stimulus. The driver sets the inputs on a falling edge and pushes the expected state once the next rising edge has passed. The monitor compares at the falling edge that follows. Because the queue is filled only after the sampling edge, each comparison lands in the single cycle in which that entry's outputs are valid. Idle steps sit between requests, so the one-cycle strobe and the held state are observed as well.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    EK_NONE,
    EK_POR,
    EK_DBG,
    EK_MAN,
    EK_MISS
  } entry_kind_e;

  localparam logic [11:0] EVT_POWERON = 12'h000;
  localparam logic [11:0] EVT_MANUAL  = 12'h020;
  localparam logic [11:0] EVT_MISS_RD = 12'h040;
  localparam logic [11:0] EVT_MISS_WR = 12'h060;

  localparam logic [XLEN-1:0] RESET_TARGET = 32'hA000_0000;
  localparam logic [XLEN-1:0] MISS_OFFSET  = 32'h0000_0400;

  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;
  localparam int SR_BL_BIT = 28;
  localparam int SR_IM_LSB = 4;
  localparam int SR_IM_W   = 4;

  localparam logic [XLEN-1:0] SR_PRIV_BITS =
    (XLEN'(1) << SR_MD_BIT) | (XLEN'(1) << SR_RB_BIT) | (XLEN'(1) << SR_BL_BIT);
  localparam logic [XLEN-1:0] SR_MASK_BITS =
    XLEN'((1 << SR_IM_W) - 1) << SR_IM_LSB;
  localparam logic [XLEN-1:0] SR_RESET_VAL = SR_PRIV_BITS | SR_MASK_BITS;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic        por_n,
  input  logic        mrst_n,
  input  logic        dbg_rst,
  input  logic        miss_req,
  output entry_kind_e kind
);
  always_comb begin
    if (!por_n)        kind = EK_POR;
    else if (dbg_rst)  kind = EK_DBG;
    else if (!mrst_n)  kind = EK_MAN;
    else if (miss_req) kind = EK_MISS;
    else               kind = EK_NONE;
  end
endmodule

// File: rtl/exc_repl_ctr.sv
module exc_repl_ctr #(
  parameter int WAYS = 4,
  localparam int RC_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            clear,
  input  logic            advance,
  input  logic [WAYS-1:0] way_dis,
  output logic [RC_W-1:0] rc_q
);
  logic [RC_W-1:0] lowest_dis;
  logic [RC_W-1:0] rc_inc;
  logic            any_dis;

  always_comb begin
    lowest_dis = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (way_dis[i]) lowest_dis = RC_W'(i);
    end
  end

  assign any_dis = |way_dis;
  assign rc_inc  = (rc_q == RC_W'(WAYS - 1)) ? '0 : rc_q + RC_W'(1);

  always_ff @(posedge clk) begin
    if (clear)        rc_q <= '0;
    else if (advance) rc_q <= any_dis ? lowest_dis : rc_inc;
  end

  logic [WAYS-1:0] dis_seen;
  logic [WAYS-1:0] below_mask;
  always_ff @(posedge clk) dis_seen <= way_dis;
  always_comb begin
    below_mask = '0;
    for (int i = 0; i < WAYS; i++) below_mask[i] = (RC_W'(i) < rc_q);
  end

  assert_wrap_count_R6: assert property (@(posedge clk) disable iff (clear)
    (advance && !any_dis) |=> (rc_q == (($past(rc_q) == RC_W'(WAYS - 1)) ? '0 : $past(rc_q) + RC_W'(1))));

  assert_pick_disabled_R7: assert property (@(posedge clk) disable iff (clear)
    (advance && any_dis) |=> (dis_seen[rc_q] && ((dis_seen & below_mask) == '0)));

  assert_clear_zero_R11: assert property (@(posedge clk)
    clear |=> (rc_q == '0));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter int ASID_W  = 8,
  parameter int VPN_LSB = 10,
  localparam int RC_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              dbg_rst,
  input  logic              miss_req,
  input  logic              miss_is_write,
  input  logic [XLEN-1:0]   miss_addr,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [WAYS-1:0]   way_dis,
  output logic              redirect,
  output logic [XLEN-1:0]   target_pc,
  output logic [11:0]       evt_code,
  output logic [XLEN-1:0]   vbr,
  output logic [XLEN-1:0]   sr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   fault_addr,
  output logic [XLEN-1:0]   pteh,
  output logic [RC_W-1:0]   repl_way,
  output logic [1:0]        status_pins
);
  localparam logic [XLEN-1:0] VPN_MASK = ~((XLEN'(1) << VPN_LSB) - XLEN'(1));

  entry_kind_e kind;
  logic        is_reset;
  logic        take_miss;
  logic        seen_por = 1'b0;
  logic [XLEN-1:0] pteh_next;

  exc_arbiter u_arb (
    .por_n    (por_n),
    .mrst_n   (mrst_n),
    .dbg_rst  (dbg_rst),
    .miss_req (miss_req),
    .kind     (kind)
  );

  assign is_reset  = (kind == EK_POR) || (kind == EK_DBG) || (kind == EK_MAN);
  assign take_miss = (kind == EK_MISS);
  assign pteh_next = (miss_addr & VPN_MASK) | XLEN'(cur_asid);

  exc_repl_ctr #(.WAYS(WAYS)) u_rc (
    .clk     (clk),
    .clear   (kind == EK_POR),
    .advance (take_miss),
    .way_dis (way_dis),
    .rc_q    (repl_way)
  );

  always_ff @(posedge clk) begin
    if (kind == EK_POR) seen_por <= 1'b1;
    redirect <= 1'b0;
    if (is_reset) begin
      redirect    <= 1'b1;
      target_pc   <= RESET_TARGET;
      evt_code    <= (kind == EK_MAN) ? EVT_MANUAL : EVT_POWERON;
      vbr         <= '0;
      sr          <= SR_RESET_VAL;
      status_pins <= (kind == EK_POR) ? 2'b11 : 2'b00;
    end else if (take_miss) begin
      redirect    <= 1'b1;
      target_pc   <= vbr + MISS_OFFSET;
      evt_code    <= miss_is_write ? EVT_MISS_WR : EVT_MISS_RD;
      spc         <= cur_pc;
      ssr         <= cur_sr;
      sr          <= cur_sr | SR_PRIV_BITS;
      fault_addr  <= miss_addr;
      pteh        <= pteh_next;
      status_pins <= 2'b00;
    end
  end

  assert_reset_entry_R2: assert property (@(posedge clk) disable iff (!seen_por)
    (!por_n || dbg_rst || !mrst_n) |=> (redirect && target_pc == RESET_TARGET && vbr == '0));

  assert_reset_prio_R1: assert property (@(posedge clk) disable iff (!seen_por)
    (por_n && !dbg_rst && !mrst_n) |=> (evt_code == EVT_MANUAL));

  assert_miss_target_R4: assert property (@(posedge clk) disable iff (!seen_por)
    (miss_req && por_n && mrst_n && !dbg_rst) |=>
      (redirect && target_pc == vbr + MISS_OFFSET && spc == $past(cur_pc)));

  assert_saved_hold_R10: assert property (@(posedge clk) disable iff (!seen_por)
    (!por_n || dbg_rst || !mrst_n) |=>
      (spc == $past(spc) && ssr == $past(ssr) && fault_addr == $past(fault_addr)));

  assert_status_por_R8: assert property (@(posedge clk) disable iff (!seen_por)
    (!por_n) |=> (status_pins == 2'b11));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!seen_por)
    (por_n && mrst_n && !dbg_rst && !miss_req) |=>
      (!redirect && $stable(sr) && $stable(evt_code) && $stable(target_pc)));
endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, mrst_n = 1'b1, dbg_rst = 1'b0;
  logic        miss_req = 1'b0, miss_is_write = 1'b0;
  logic [31:0] miss_addr = '0, cur_pc = '0, cur_sr = '0;
  logic [7:0]  cur_asid = '0;
  logic [3:0]  way_dis = '0;
  logic        redirect;
  logic [31:0] target_pc, vbr, sr, spc, ssr, fault_addr, pteh;
  logic [11:0] evt_code;
  logic [1:0]  repl_way, status_pins;

  always #5 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .dbg_rst(dbg_rst),
    .miss_req(miss_req), .miss_is_write(miss_is_write), .miss_addr(miss_addr),
    .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_asid(cur_asid), .way_dis(way_dis),
    .redirect(redirect), .target_pc(target_pc), .evt_code(evt_code), .vbr(vbr),
    .sr(sr), .spc(spc), .ssr(ssr), .fault_addr(fault_addr), .pteh(pteh),
    .repl_way(repl_way), .status_pins(status_pins)
  );

  typedef struct {
    string       tag;
    logic        rd;
    logic [31:0] tgt, vb, s, sp, ss, fa, pe;
    logic [11:0] ev;
    logic [1:0]  rc, st;
  } exp_t;

  exp_t q[$];
  exp_t m;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string name, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, name, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "redirect R9", 32'(redirect), 32'(e.rd));
      chk(e.tag, "target_pc", target_pc, e.tgt);
      chk(e.tag, "evt_code", 32'(evt_code), 32'(e.ev));
      chk(e.tag, "vbr", vbr, e.vb);
      chk(e.tag, "sr", sr, e.s);
      chk(e.tag, "spc", spc, e.sp);
      chk(e.tag, "ssr", ssr, e.ss);
      chk(e.tag, "fault_addr", fault_addr, e.fa);
      chk(e.tag, "pteh", pteh, e.pe);
      chk(e.tag, "repl_way", 32'(repl_way), 32'(e.rc));
      chk(e.tag, "status_pins", 32'(status_pins), 32'(e.st));
    end
  end

  task automatic step(string tag, logic p_n, logic m_n, logic dbg, logic mr, logic wr,
                      logic [31:0] addr, logic [31:0] pc, logic [31:0] s,
                      logic [7:0] asid, logic [3:0] dis);
    @(negedge clk);
    por_n = p_n; mrst_n = m_n; dbg_rst = dbg; miss_req = mr; miss_is_write = wr;
    miss_addr = addr; cur_pc = pc; cur_sr = s; cur_asid = asid; way_dis = dis;
    m.tag = tag;
    m.rd  = 1'b0;
    if (!p_n || dbg || !m_n) begin
      m.rd = 1'b1; m.tgt = 32'hA000_0000; m.vb = 32'h0; m.s = 32'h7000_00F0;
      m.ev = (!p_n || dbg) ? 12'h000 : 12'h020;
      m.st = (!p_n) ? 2'b11 : 2'b00;
      if (!p_n) m.rc = 2'd0;
    end else if (mr) begin
      m.rd = 1'b1; m.tgt = m.vb + 32'h400; m.ev = wr ? 12'h060 : 12'h040;
      m.sp = pc; m.ss = s; m.s = s | 32'h7000_0000; m.fa = addr;
      m.pe = {addr[31:10], 2'b00, asid}; m.st = 2'b00;
      if (dis == 4'b0) m.rc = m.rc + 2'd1;
      else if (dis[0]) m.rc = 2'd0;
      else if (dis[1]) m.rc = 2'd1;
      else if (dis[2]) m.rc = 2'd2;
      else m.rc = 2'd3;
    end
    @(posedge clk);
    #1;
    q.push_back(m);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 8'h0, 4'h0);
  endtask

  initial begin
    m.sp = 'x; m.ss = 'x; m.fa = 'x; m.pe = 'x; m.rc = 'x;
    m.tgt = 'x; m.vb = 'x; m.s = 'x; m.ev = 'x; m.st = 'x;
    step("R1 R2 R8 R11 power-on", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 0);
    step("R2 R11 power-on held", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 0);
    idle("R9 idle after reset");
    step("R3 R4 R5 R6 read miss", 1, 1, 0, 1, 0, 32'h1234_5678, 32'h8000_0100, 32'h0000_0003, 8'h5A, 4'h0);
    idle("R9 idle after miss");
    step("R3 R4 R5 R6 write miss", 1, 1, 0, 1, 1, 32'hDEAD_BEEF, 32'h8000_0200, 32'h4000_0010, 8'hA5, 4'h0);
    step("R6 count 3", 1, 1, 0, 1, 0, 32'h0000_0C00, 32'h8000_0300, 32'h0, 8'h01, 4'h0);
    step("R6 wrap to 0", 1, 1, 0, 1, 1, 32'hFFFF_FFFF, 32'h8000_0400, 32'h0, 8'hFF, 4'h0);
    step("R7 lowest disabled 1", 1, 1, 0, 1, 0, 32'h0040_0400, 32'h8000_0500, 32'h0, 8'h10, 4'b0110);
    step("R7 only way 3", 1, 1, 0, 1, 0, 32'h0080_03FF, 32'h8000_0600, 32'h0, 8'h20, 4'b1000);
    step("R7 way 0 disabled", 1, 1, 0, 1, 1, 32'h0100_0000, 32'h8000_0700, 32'h0, 8'h30, 4'b1111);
    step("R1 R8 R10 R11 manual reset", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle("R9 idle after manual");
    step("R1 debug over manual", 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R1 R8 power-on over debug", 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R3 miss after power-on", 1, 1, 0, 1, 0, 32'h0000_1000, 32'h8000_0800, 32'h0000_00F0, 8'h07, 4'h0);
    step("R10 miss with manual reset ignored", 1, 0, 0, 1, 1, 32'h5555_5555, 32'h9999_9999, 32'h1, 8'h77, 4'h0);
    step("R10 miss with debug reset ignored", 1, 1, 1, 1, 0, 32'h6666_6666, 32'hAAAA_AAAA, 32'h2, 8'h66, 4'h2);
    idle("R9 final idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule